// File: doc/BRIEF.md
# Serial EEPROM Write-Protection Controller

This block owns the protection state of a two-wire serial EEPROM and rules on every write the serial front end decodes. The front end hands it a stream of events: the start of an addressed write (carrying the 16-bit word address), each received data byte, the stop condition, and a single-byte random read. For every data byte the block returns an acknowledge decision. At stop it either signals that the array write may commit, signals that the write was accepted but is to be thrown away, applies a volatile latch update, or launches a nonvolatile programming cycle. A read of the protection register at address FFFFh returns its contents, and the block also tells the front end to clear its address counter.

Protection is layered. A write-enable latch must be set before any array write is acknowledged. A second register-enable latch, which can only be set on top of the first, must be set before the sticky lock bits can change. Two lock bits select a protected upper region of the 16K-byte array. A hardware-protect enable bit, together with the external protect pin, freezes those sticky bits. The nonvolatile programming time is modelled as a busy counter of `NV_CYCLES` clocks. Staged lock bits only take effect when that counter expires.

Events arrive on a valid/ready channel. Responses to data and read events leave on a second valid/ready channel that holds one entry. A response stays stable until it is taken. While an untaken response is pending, `evt_ready` is low, so back-pressure from the response side stalls the event side. Start and stop events produce no response.

Top module: `wpr_ctrl`

## Requirements
- R1: After reset both enable latches, both lock bits and the protect-enable bit are 0, `nv_busy` is 0, and a register read returns 00h.
- R2: A read event at FFFFh responds with ack=1 and data {bit7 protect-enable, bits 6:5 zero, bits 4:3 lock bits, bit2 register-enable latch, bit1 write-enable latch, bit0 zero}. It pulses `addr_clr` in the same cycle as that response. A read at any other address responds with ack=0, data 00h and no `addr_clr`.
- R3: A first data byte to FFFFh with a 1 in bit 0, 5 or 6 is not acknowledged, and the following stop changes nothing.
- R4: A first data byte of 02h to FFFFh is acknowledged, and at stop it sets the write-enable latch and clears the register-enable latch. A byte of 00h clears both latches. Neither starts a busy period.
- R5: A byte of 06h to FFFFh sets both latches at stop if the write-enable latch is already 1 and the register-enable latch is 0. With the write-enable latch at 0 the byte is not acknowledged.
- R6: While the write-enable latch is 0, data bytes to any address other than FFFFh are not acknowledged, and stop produces no pulse.
- R7: Lock bits (bit4:bit3 of the register) select the protected region of the 14-bit array offset: 00 none, 01 3000h-3FFFh, 10 2000h-3FFFh, 11 all. A write to a protected address is acknowledged, and its stop pulses `wr_discard` with no `nv_start`.
- R8: An acknowledged write to an unprotected array address pulses `arr_commit` and `nv_start` at stop. It holds `nv_busy` for exactly `NV_CYCLES` cycles and clears the register-enable latch.
- R9: With the register-enable latch at 1, a first byte to FFFFh with bits 2:1 = 11 is acknowledged. Its stop pulses `nv_start` and clears the register-enable latch. Bits 7 and 4:3 of the byte become the protect-enable and lock bits only when the busy period ends.
- R10: While `wp_pin` and the protect-enable bit are both 1, a register write as in R9 is acknowledged but discarded, and the register-enable latch is kept. Enable latches and unprotected array addresses stay writable.
- R11: Only the first data byte after a start addressed to FFFFh is acknowledged. Later bytes are refused and do not cancel the first.
- R12: While `nv_busy` is 1, every data byte is refused, and the stop that follows produces no pulse.
- R13: `evt_ready` equals `!resp_valid || resp_ready`. A response that is not taken keeps `resp_ack` and `resp_rdata` stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_pin | input | 1 | External hardware write-protect level |
| evt_valid | input | 1 | Event present |
| evt_ready | output | 1 | Event accepted on this cycle when valid |
| evt_kind | input | 2 | 0 start, 1 data byte, 2 stop, 3 random read |
| evt_addr | input | 16 | Word address for start and read events |
| evt_data | input | 8 | Data byte for data events |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Response taken on this cycle when valid |
| resp_ack | output | 1 | Acknowledge decision, or register-hit for reads |
| resp_rdata | output | 8 | Register read data (00h for data responses) |
| addr_clr | output | 1 | Pulse: front end clears its address counter |
| arr_commit | output | 1 | Pulse at stop: array write may be stored |
| wr_discard | output | 1 | Pulse at stop: acknowledged write thrown away |
| nv_start | output | 1 | Pulse: nonvolatile programming cycle begins |
| nv_busy | output | 1 | Nonvolatile cycle in progress |

## Verification
The hardest state to reach is the one where the hardware lock is actually in force. Getting there takes a full chain of writes: set the write-enable latch, then the register-enable latch, then a nonvolatile register write with the protect-enable bit, wait out the busy period, and only then raise `wp_pin`. The stimulus walks this chain in order. At each step it checks that the volatile latches and the unprotected array region stay writable while the lock bits refuse to move. A data byte that lands inside the busy window is issued straight after a register commit, so the refusal is observed before the staged bits appear.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

  typedef enum logic [1:0] {
    EV_START = 2'd0,
    EV_DATA  = 2'd1,
    EV_STOP  = 2'd2,
    EV_READ  = 2'd3
  } ev_kind_e;

  typedef enum logic [2:0] {
    ACT_NONE    = 3'd0,
    ACT_VOL     = 3'd1,
    ACT_REG_NV  = 3'd2,
    ACT_ARR_NV  = 3'd3,
    ACT_DISCARD = 3'd4
  } act_e;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bl;
  } nv_bits_t;

  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ZERO_MASK = 8'h61;

endpackage

// File: rtl/wpr_lock_decode.sv
module wpr_lock_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned ARRAY_AW = 14
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bl,
  output logic              locked
);
  localparam int unsigned TOP = ARRAY_AW - 1;

  logic [1:0] quarter;
  assign quarter = addr[TOP -: 2];

  always_comb begin
    unique case (bl)
      2'b00:   locked = 1'b0;
      2'b01:   locked = (quarter == 2'b11);
      2'b10:   locked = quarter[1];
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpr_write_policy.sv
module wpr_write_policy
  import wpr_pkg::*;
(
  input  logic              is_reg,
  input  logic              first_byte,
  input  logic [BYTE_W-1:0] data,
  input  logic              wel,
  input  logic              rwel,
  input  logic              hw_prot,
  input  logic              busy,
  input  logic              locked,
  output logic              ack,
  output act_e              act,
  output logic              next_wel,
  output logic              next_rwel,
  output nv_bits_t          stage
);
  logic illegal;
  assign illegal = |(data & ZERO_MASK);

  always_comb begin
    ack       = 1'b0;
    act       = ACT_NONE;
    next_wel  = wel;
    next_rwel = rwel;
    stage     = '{wpen: data[7], bl: data[4:3]};
    if (busy) begin
      ack = 1'b0;
    end else if (is_reg) begin
      if (!first_byte || illegal) begin
        ack = 1'b0;
      end else if (data[2:1] == 2'b11 && rwel) begin
        ack = 1'b1;
        act = hw_prot ? ACT_DISCARD : ACT_REG_NV;
      end else if (data == 8'h06 && wel) begin
        ack = 1'b1;
        act = ACT_VOL;
        next_wel  = 1'b1;
        next_rwel = 1'b1;
      end else if (data == 8'h02) begin
        ack = 1'b1;
        act = ACT_VOL;
        next_wel  = 1'b1;
        next_rwel = 1'b0;
      end else if (data == 8'h00) begin
        ack = 1'b1;
        act = ACT_VOL;
        next_wel  = 1'b0;
        next_rwel = 1'b0;
      end
    end else if (wel) begin
      ack = 1'b1;
      act = locked ? ACT_DISCARD : ACT_ARR_NV;
    end
  end
endmodule

// File: rtl/wpr_nv_timer.sv
module wpr_nv_timer #(
  parameter int unsigned NV_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(NV_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(NV_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/wpr_ctrl.sv
module wpr_ctrl
  import wpr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned ARRAY_AW  = 14,
  parameter int unsigned NV_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [1:0]        evt_kind,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [7:0]        evt_data,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_ack,
  output logic [7:0]        resp_rdata,
  output logic              addr_clr,
  output logic              arr_commit,
  output logic              wr_discard,
  output logic              nv_start,
  output logic              nv_busy
);
  localparam logic [ADDR_W-1:0] REG_ADDR = {ADDR_W{1'b1}};

  ev_kind_e          kind;
  logic              accept;
  logic [ADDR_W-1:0] cur_addr_q;
  logic              first_q;
  logic              wel_q, rwel_q;
  nv_bits_t          nv_q, stg_q;
  act_e              pend_q;
  logic              pend_wel_q, pend_rwel_q;
  nv_bits_t          pend_stg_q;

  logic              locked, hw_prot, is_reg;
  logic              pol_ack, pol_wel, pol_rwel;
  act_e              pol_act;
  nv_bits_t          pol_stg;
  logic              timer_start, timer_busy, timer_done;
  logic [7:0]        reg_value;

  assign kind      = ev_kind_e'(evt_kind);
  assign evt_ready = !resp_valid || resp_ready;
  assign accept    = evt_valid && evt_ready;
  assign hw_prot   = wp_pin && nv_q.wpen;
  assign is_reg    = (cur_addr_q == REG_ADDR);
  assign reg_value = {nv_q.wpen, 2'b00, nv_q.bl, rwel_q, wel_q, 1'b0};
  assign nv_busy   = timer_busy;

  wpr_lock_decode #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW)) u_lock (
    .addr   (cur_addr_q),
    .bl     (nv_q.bl),
    .locked (locked)
  );

  wpr_write_policy u_policy (
    .is_reg     (is_reg),
    .first_byte (first_q),
    .data       (evt_data),
    .wel        (wel_q),
    .rwel       (rwel_q),
    .hw_prot    (hw_prot),
    .busy       (timer_busy),
    .locked     (locked),
    .ack        (pol_ack),
    .act        (pol_act),
    .next_wel   (pol_wel),
    .next_rwel  (pol_rwel),
    .stage      (pol_stg)
  );

  assign timer_start = accept && (kind == EV_STOP) &&
                       (pend_q == ACT_REG_NV || pend_q == ACT_ARR_NV);

  wpr_nv_timer #(.NV_CYCLES(NV_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (timer_start),
    .busy  (timer_busy),
    .done  (timer_done)
  );

  // Transaction tracking: address, first-byte flag and pending action
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr_q  <= '0;
      first_q     <= 1'b1;
      pend_q      <= ACT_NONE;
      pend_wel_q  <= 1'b0;
      pend_rwel_q <= 1'b0;
      pend_stg_q  <= '0;
    end else if (accept) begin
      unique case (kind)
        EV_START: begin
          cur_addr_q <= evt_addr;
          first_q    <= 1'b1;
          pend_q     <= ACT_NONE;
        end
        EV_DATA: begin
          first_q <= 1'b0;
          if (pol_ack) begin
            pend_q      <= pol_act;
            pend_wel_q  <= pol_wel;
            pend_rwel_q <= pol_rwel;
            pend_stg_q  <= pol_stg;
          end else if (first_q) begin
            pend_q <= ACT_NONE;
          end
        end
        default: begin
          first_q <= 1'b1;
          pend_q  <= ACT_NONE;
        end
      endcase
    end
  end

  // Protection state: volatile latches, staged and committed sticky bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
      nv_q   <= '0;
      stg_q  <= '0;
    end else begin
      if (timer_done) nv_q <= stg_q;
      if (accept && kind == EV_STOP) begin
        unique case (pend_q)
          ACT_VOL: begin
            wel_q  <= pend_wel_q;
            rwel_q <= pend_rwel_q;
          end
          ACT_REG_NV: begin
            stg_q  <= pend_stg_q;
            rwel_q <= 1'b0;
          end
          ACT_ARR_NV: begin
            stg_q  <= nv_q;
            rwel_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // Stop-time pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_commit <= 1'b0;
      wr_discard <= 1'b0;
      nv_start   <= 1'b0;
    end else begin
      arr_commit <= accept && kind == EV_STOP && pend_q == ACT_ARR_NV;
      wr_discard <= accept && kind == EV_STOP && pend_q == ACT_DISCARD;
      nv_start   <= timer_start;
    end
  end

  // Response channel (one entry, held until taken)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
      resp_rdata <= '0;
      addr_clr   <= 1'b0;
    end else begin
      addr_clr <= 1'b0;
      if (accept && kind == EV_DATA) begin
        resp_valid <= 1'b1;
        resp_ack   <= pol_ack;
        resp_rdata <= '0;
      end else if (accept && kind == EV_READ) begin
        resp_valid <= 1'b1;
        resp_ack   <= (evt_addr == REG_ADDR);
        resp_rdata <= (evt_addr == REG_ADDR) ? reg_value : 8'h00;
        addr_clr   <= (evt_addr == REG_ADDR);
      end else if (resp_ready) begin
        resp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wpr_ctrl_sva.sv
module wpr_ctrl_sva #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic [1:0]        evt_kind,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic              resp_ack,
  input logic [7:0]        resp_rdata,
  input logic              addr_clr,
  input logic              arr_commit,
  input logic              wr_discard,
  input logic              nv_start,
  input logic              nv_busy,
  input logic              wel_q,
  input logic [ADDR_W-1:0] cur_addr_q
);
  assert_ready_rule_R13: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ready == (!resp_valid || resp_ready));

  assert_resp_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_ack) && $stable(resp_rdata)));

  assert_busy_refuse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_busy && evt_valid && evt_ready && evt_kind == 2'd1) |=> (resp_valid && !resp_ack));

  assert_nowel_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready && evt_kind == 2'd1 && !wel_q && cur_addr_q != {ADDR_W{1'b1}})
      |=> (resp_valid && !resp_ack));

  assert_nvstart_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start |-> nv_busy);

  assert_discard_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_commit, wr_discard}) && !(wr_discard && nv_start));

  assert_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_rdata[0] == 1'b0 && resp_rdata[6:5] == 2'b00));

  assert_clr_with_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_clr |-> (resp_valid && resp_ack));
endmodule

bind wpr_ctrl wpr_ctrl_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_valid  (evt_valid),
  .evt_ready  (evt_ready),
  .evt_kind   (evt_kind),
  .resp_valid (resp_valid),
  .resp_ready (resp_ready),
  .resp_ack   (resp_ack),
  .resp_rdata (resp_rdata),
  .addr_clr   (addr_clr),
  .arr_commit (arr_commit),
  .wr_discard (wr_discard),
  .nv_start   (nv_start),
  .nv_busy    (nv_busy),
  .wel_q      (wel_q),
  .cur_addr_q (cur_addr_q)
);

// File: tb/wpr_ctrl_tb.sv
module wpr_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_pin = 1'b0;
  logic evt_valid = 1'b0;
  logic evt_ready;
  logic [1:0] evt_kind = 2'd0;
  logic [15:0] evt_addr = 16'h0;
  logic [7:0] evt_data = 8'h0;
  logic resp_valid, resp_ack, addr_clr, arr_commit, wr_discard, nv_start, nv_busy;
  logic resp_ready = 1'b1;
  logic [7:0] resp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpr_ctrl #(.NV_CYCLES(NV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_kind(evt_kind),
    .evt_addr(evt_addr), .evt_data(evt_data),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_ack(resp_ack),
    .resp_rdata(resp_rdata), .addr_clr(addr_clr), .arr_commit(arr_commit),
    .wr_discard(wr_discard), .nv_start(nv_start), .nv_busy(nv_busy)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  int m_wel = 0, m_rwel = 0, m_bl = 0, m_wpen = 0;
  int m_sbl = 0, m_swpen = 0;
  int m_busy = 0;
  int m_addr = 0, m_first = 1;
  int m_pend = 0;            // 0 none,1 vol,2 regnv,3 arrnv,4 discard
  int m_pwel = 0, m_prwel = 0, m_pbl = 0, m_pwpen = 0;
  // Expected outputs
  int e_rv = 0, e_ack = 0, e_rd = 0;
  int e_clr = 0, e_commit = 0, e_disc = 0, e_nv = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int reg_val();
    return (m_wpen << 7) | (m_bl << 3) | (m_rwel << 2) | (m_wel << 1);
  endfunction

  function automatic int is_locked(input int a);
    int off;
    off = a & 16'h3FFF;
    if (m_bl == 3) return 1;
    if (m_bl == 2) return (off >= 16'h2000) ? 1 : 0;
    if (m_bl == 1) return (off >= 16'h3000) ? 1 : 0;
    return 0;
  endfunction

  // Model step for one accepted event (state as seen before the edge)
  task automatic model_event(input int k, input int a, input int d);
    int ack, act, nw, nr;
    if (k == 0) begin
      m_addr = a; m_first = 1; m_pend = 0;
    end else if (k == 1) begin
      ack = 0; act = 0; nw = m_wel; nr = m_rwel;
      if (m_busy > 0) ack = 0;                                   // R12
      else if (m_addr == 16'hFFFF) begin
        if (m_first == 0) ack = 0;                               // R11
        else if ((d & 8'h61) != 0) ack = 0;                      // R3
        else if (((d >> 1) & 3) == 3 && m_rwel == 1) begin       // R9 / R10
          ack = 1; act = (wp_pin && m_wpen == 1) ? 4 : 2;
        end else if (d == 8'h06 && m_wel == 1) begin ack = 1; act = 1; nw = 1; nr = 1; end // R5
        else if (d == 8'h02) begin ack = 1; act = 1; nw = 1; nr = 0; end          // R4
        else if (d == 8'h00) begin ack = 1; act = 1; nw = 0; nr = 0; end
      end else if (m_wel == 1) begin                             // R6
        ack = 1; act = is_locked(m_addr) ? 4 : 3;                // R7 / R8
      end
      if (ack == 1) begin
        m_pend = act; m_pwel = nw; m_prwel = nr;
        m_pbl = (d >> 3) & 3; m_pwpen = (d >> 7) & 1;
      end else if (m_first == 1) m_pend = 0;
      m_first = 0;
      e_rv = 1; e_ack = ack; e_rd = 0;
    end else if (k == 2) begin
      if (m_pend == 1) begin m_wel = m_pwel; m_rwel = m_prwel; end
      else if (m_pend == 2) begin
        m_sbl = m_pbl; m_swpen = m_pwpen; m_rwel = 0; m_busy = NV + 1; e_nv = 1;
      end else if (m_pend == 3) begin
        m_sbl = m_bl; m_swpen = m_wpen; m_rwel = 0; m_busy = NV + 1; e_nv = 1; e_commit = 1;
      end else if (m_pend == 4) e_disc = 1;
      m_pend = 0; m_first = 1;
    end else begin
      e_rv = 1;
      if (a == 16'hFFFF) begin e_ack = 1; e_rd = reg_val(); e_clr = 1; end
      else begin e_ack = 0; e_rd = 0; end
      m_pend = 0; m_first = 1;
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (m_busy > 0) begin
        m_busy--;
        if (m_busy == 0) begin m_bl = m_sbl; m_wpen = m_swpen; end  // R9 commit
      end
      chk(nv_busy == (m_busy > 0), "R8 nv_busy", nv_busy, m_busy > 0);
      chk(nv_start == e_nv, "R8 nv_start", nv_start, e_nv);
      chk(arr_commit == e_commit, "R8 arr_commit", arr_commit, e_commit);
      chk(wr_discard == e_disc, "R7 wr_discard", wr_discard, e_disc);
      chk(addr_clr == e_clr, "R2 addr_clr", addr_clr, e_clr);
      chk(resp_valid == e_rv, "R13 resp_valid", resp_valid, e_rv);
      chk(evt_ready == (!resp_valid || resp_ready), "R13 evt_ready", evt_ready, !resp_valid || resp_ready);
      if (e_rv == 1) begin
        chk(resp_ack == e_ack, "R2 resp_ack", resp_ack, e_ack);
        chk(resp_rdata == e_rd[7:0], "R2 resp_rdata", resp_rdata, e_rd);
        if (resp_ready) e_rv = 0;
      end
      e_nv = 0; e_commit = 0; e_disc = 0; e_clr = 0;
    end
  end

  task automatic ev(input int k, input int a, input int d);
    @(negedge clk);
    evt_valid = 1'b1; evt_kind = k[1:0]; evt_addr = a[15:0]; evt_data = d[7:0];
    while (!evt_ready) @(negedge clk);
    @(posedge clk);
    model_event(k, a, d);
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    ev(0, a, 0); ev(1, a, d); ev(2, 0, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_reg(input int v, input string req);
    ev(3, 16'hFFFF, 0);
    chk(resp_rdata == v[7:0], req, resp_rdata, v);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1: reset state
    chk(nv_busy == 0, "R1 busy after reset", nv_busy, 0);
    expect_reg(8'h00, "R1 register after reset");
    // R2: read elsewhere
    ev(3, 16'h0123, 0);
    // R6: array write with latch clear
    wr(16'h0100, 8'h55);
    // R5: 06h refused with WEL=0
    wr(16'hFFFF, 8'h06);
    expect_reg(8'h00, "R5 refused set");
    // R3: forbidden bits
    wr(16'hFFFF, 8'h03);
    wr(16'hFFFF, 8'h22);
    wr(16'hFFFF, 8'h42);
    expect_reg(8'h00, "R3 no change");
    // R11 + R4: first byte 02h taken, second refused
    ev(0, 16'hFFFF, 0); ev(1, 16'hFFFF, 8'h02); ev(1, 16'hFFFF, 8'h00); ev(2, 0, 0);
    expect_reg(8'h02, "R4 R11 wel set");
    // R5: set RWEL
    wr(16'hFFFF, 8'h06);
    expect_reg(8'h06, "R5 rwel set");
    // R9: lock bits 01, then R12 refusal inside busy
    wr(16'hFFFF, 8'h0E);
    wr(16'h0000, 8'h11);
    expect_reg(8'h02, "R9 staged bits hidden while busy");
    idle(NV + 2);
    expect_reg(8'h0A, "R9 lock bits committed");
    // R7 / R8 with 01
    wr(16'h3000, 8'hAA);
    wr(16'h2FFF, 8'hAA);
    idle(NV + 2);
    // R8: page write to unlocked region, second byte also acked
    ev(0, 16'h0010, 0); ev(1, 0, 8'h01); ev(1, 0, 8'h02); ev(2, 0, 0);
    idle(NV + 2);
    // Enable bit and lock 10
    wr(16'hFFFF, 8'h06);
    wr(16'hFFFF, 8'h96);
    idle(NV + 2);
    expect_reg(8'h92, "R9 wpen and lock 10");
    wr(16'h2000, 8'h33);
    wr(16'h1FFF, 8'h33);
    idle(NV + 2);
    // R10: hardware protection active
    @(posedge clk); #1 wp_pin = 1'b1;
    wr(16'hFFFF, 8'h06);
    wr(16'hFFFF, 8'h1E);
    idle(NV + 2);
    expect_reg(8'h96, "R10 sticky bits frozen, rwel kept");
    wr(16'h1000, 8'h44);
    idle(NV + 2);
    wr(16'h3FFF, 8'h44);
    wr(16'hFFFF, 8'h00);
    expect_reg(8'h90, "R10 latches still writable");
    // Release protection, clear bits, then lock 11
    @(posedge clk); #1 wp_pin = 1'b0;
    wr(16'hFFFF, 8'h02);
    wr(16'hFFFF, 8'h06);
    wr(16'hFFFF, 8'h1E);
    idle(NV + 2);
    expect_reg(8'h1A, "R9 lock 11");
    wr(16'h0000, 8'h77);
    // R13: back-pressure on the response channel
    ev(0, 16'hFFFF, 0);
    @(posedge clk); #1 resp_ready = 1'b0;
    ev(1, 16'hFFFF, 8'h02);
    for (int i = 0; i < 3; i++) begin
      chk(evt_ready == 1'b0, "R13 stalled", evt_ready, 0);
      chk(resp_valid == 1'b1 && resp_ack == 1'b1, "R13 held response", resp_ack, 1);
      @(negedge clk);
    end
    @(posedge clk); #1 resp_ready = 1'b1;
    ev(2, 0, 0);
    expect_reg(8'h1A, "R13 final register");
    idle(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule